// File: doc/BRIEF.md
# Masked Interrupt Controller with GPIO Group Cascade

This block collects interrupt requests from 32 sources into one CPU interrupt line. A request latches a bit in a sticky status register. A mask register decides which latched bits the CPU may see. The pending view is the status with every masked bit forced to zero. The CPU line is high whenever any pending bit is set. A priority encoder names the lowest-numbered pending source and raises a valid flag alongside it.

A GPIO front end takes 128 per-pin interrupt pulses. The pins correspond to external interrupt numbers 48 to 175, with pin p being number 48+p. Each pin latches its own flag, so software can see which pin fired. The pins form four groups of 32, and each group drives one controller source while any of its flags is set. The four group sources sit at indices GRP_BASE to GRP_BASE+3, which is 24 to 27 by default.

Software uses a simple register port with a word address and a write strobe. Reads are combinational. It can load the mask, set mask bits or clear mask bits with write-1 patterns, clear status bits, and clear GPIO pin flags.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset, status, pending and all GPIO pin flags read 0, mask reads 0xFFFFFFFF, irq_o is 0 and irq_valid_o is 0.
- R2: A high src_req_i[n] at a clock edge sets status bit n after that edge (read at word 0, byte 0x00). The bit stays set until it is cleared.
- R3: Pending (read at 0x10) equals status AND NOT mask, with no extra cycle of delay. irq_o is high exactly when pending is non-zero.
- R4: A write to 0x04 loads the mask. A write to 0x08 sets the mask bits given as 1s. A write to 0x0C clears the mask bits given as 1s. The mask reads back at 0x04.
- R5: Writing 1s to 0x14 clears those status bits, and so also their pending bits. A request at the same edge wins, so the bit stays set.
- R6: When pending is non-zero, irq_valid_o is 1 and irq_idx_o is the lowest set pending bit. For example, with bits 23 and 27 pending the index is 23. When pending is zero, irq_valid_o is 0.
- R7: A pulse on gpio_pin_i[p] sets pin flag p. Flags of group g = p/32 read at 0x20+4g, with pin p at bit p%32.
- R8: Status bit GRP_BASE+g is set at every edge while any flag of group g is set, so clearing it in status does not hold until the flags are cleared. Writing 1s to 0x20+4g clears those flags, and a pin pulse at the same edge wins.
- R9: Writes to the read-only words at 0x00 and 0x10 change nothing.
- R10: Unmasking a source that is already latched makes it pending, and raises irq_o, right after the mask write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_req_i | input | 32 | Per-source request, sampled at each edge |
| gpio_pin_i | input | 128 | Per-pin interrupt pulses, external numbers 48..175 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | CPU interrupt line |
| irq_valid_o | output | 1 | A pending source exists |
| irq_idx_o | output | 5 | Lowest pending source index |

## Verification
Register writes, source requests and pin flags all take effect one edge after they are driven. Pending, irq_o and the encoder outputs follow status and mask with no further delay. A GPIO pin reaches status two edges after its pulse: one edge latches the flag, and the next latches the group bit.

The bench drives inputs on the falling edge and updates its model at the rising edge. It then samples every register and output 1 ns after that rising edge. Reads use the address port alone with the write strobe low, so reading never disturbs the state.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 6;
  localparam int GPIO_GRPS    = 4;
  localparam int PINS_PER_GRP = 32;
  localparam int GRP_BASE     = 24;

  // word offsets (byte address >> 2)
  localparam logic [3:0] W_STAT  = 4'd0;
  localparam logic [3:0] W_MASK  = 4'd1;
  localparam logic [3:0] W_MSET  = 4'd2;
  localparam logic [3:0] W_MCLR  = 4'd3;
  localparam logic [3:0] W_PEND  = 4'd4;
  localparam logic [3:0] W_SCLR  = 4'd5;
  localparam logic [3:0] W_GFLAG = 4'd8;

  typedef enum logic [1:0] {
    MASK_HOLD = 2'd0,
    MASK_LOAD = 2'd1,
    MASK_SET  = 2'd2,
    MASK_CLR  = 2'd3
  } mask_op_e;
endpackage

// File: rtl/irq_gpio_fold.sv
module irq_gpio_fold #(
  parameter int GRPS = 4,
  parameter int PINS = 32,
  localparam int TOT = GRPS * PINS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [TOT-1:0]  pin_i,
  input  logic [GRPS-1:0] clr_en_i,
  input  logic [PINS-1:0] clr_bits_i,
  output logic [TOT-1:0]  flags_o,
  output logic [GRPS-1:0] grp_o
);
  logic [TOT-1:0] flags_q;

  for (genvar g = 0; g < GRPS; g++) begin : g_grp
    logic [PINS-1:0] clr_g;
    assign clr_g = clr_en_i[g] ? clr_bits_i : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q[g*PINS +: PINS] <= '0;
      else         flags_q[g*PINS +: PINS] <= (flags_q[g*PINS +: PINS] & ~clr_g)
                                            | pin_i[g*PINS +: PINS];
    end

    assign grp_o[g] = |flags_q[g*PINS +: PINS];

    // a pin pulse always leaves its flag set
    p_pin_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ((flags_q[g*PINS +: PINS] & $past(pin_i[g*PINS +: PINS]))
                == $past(pin_i[g*PINS +: PINS])));
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_ctrl_pkg::*;
#(
  parameter int N = 32
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  mask_op_e mask_op_i,
  input  logic [N-1:0] mask_val_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] status_q, mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    unique case (mask_op_i)
      MASK_LOAD: mask_d = mask_val_i;
      MASK_SET:  mask_d = mask_q | mask_val_i;
      MASK_CLR:  mask_d = mask_q & ~mask_val_i;
      default:   mask_d = mask_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= (status_q & ~clr_i) | set_i;  // set wins
      mask_q   <= mask_d;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign pend_o   = status_q & ~mask_q;

  p_req_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & $past(set_i)) == $past(set_i)));

  p_status_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((status_q ^ $past(status_q)) & ~($past(set_i) | $past(clr_i))) == '0));

  p_mask_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_op_i == MASK_HOLD) |=> $stable(mask_q));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     pend_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |pend_i;

  p_lowest_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (pend_i[idx_o] && ((pend_i & ((N'(1) << idx_o) - N'(1))) == '0)));
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int GRPS  = GPIO_GRPS,
  parameter int PINS  = PINS_PER_GRP,
  parameter int GBASE = GRP_BASE,
  localparam int IDX_W = $clog2(DW),
  localparam int TOT   = GRPS * PINS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    src_req_i,
  input  logic [TOT-1:0]   gpio_pin_i,
  input  logic             reg_we_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_o,
  output logic             irq_valid_o,
  output logic [IDX_W-1:0] irq_idx_o
);
  logic [3:0]      waddr;
  logic [DW-1:0]   status, mask, pend, set_vec, sclr_vec;
  logic [TOT-1:0]  flags;
  logic [GRPS-1:0] grp, gclr_en;
  mask_op_e        mask_op;

  assign waddr = reg_addr_i[5:2];

  always_comb begin
    mask_op  = MASK_HOLD;
    sclr_vec = '0;
    gclr_en  = '0;
    if (reg_we_i) begin
      unique case (waddr)
        W_MASK:  mask_op  = MASK_LOAD;
        W_MSET:  mask_op  = MASK_SET;
        W_MCLR:  mask_op  = MASK_CLR;
        W_SCLR:  sclr_vec = reg_wdata_i;
        default: ;
      endcase
      for (int g = 0; g < GRPS; g++) begin
        if (waddr == W_GFLAG + 4'(g)) gclr_en[g] = 1'b1;
      end
    end
  end

  assign set_vec = src_req_i | (DW'(grp) << GBASE);

  irq_gpio_fold #(.GRPS(GRPS), .PINS(PINS)) u_gpio (
    .clk_i, .rst_ni,
    .pin_i      (gpio_pin_i),
    .clr_en_i   (gclr_en),
    .clr_bits_i (reg_wdata_i[PINS-1:0]),
    .flags_o    (flags),
    .grp_o      (grp)
  );

  irq_src_regs #(.N(DW)) u_regs (
    .clk_i, .rst_ni,
    .set_i      (set_vec),
    .clr_i      (sclr_vec),
    .mask_op_i  (mask_op),
    .mask_val_i (reg_wdata_i),
    .status_o   (status),
    .mask_o     (mask),
    .pend_o     (pend)
  );

  irq_prio_enc #(.N(DW)) u_enc (
    .clk_i, .rst_ni,
    .pend_i  (pend),
    .valid_o (irq_valid_o),
    .idx_o   (irq_idx_o)
  );

  assign irq_o = |pend;

  always_comb begin
    reg_rdata_o = '0;
    unique case (waddr)
      W_STAT:  reg_rdata_o = status;
      W_MASK:  reg_rdata_o = mask;
      W_PEND:  reg_rdata_o = pend;
      default: ;
    endcase
    for (int g = 0; g < GRPS; g++) begin
      if (waddr == W_GFLAG + 4'(g)) reg_rdata_o = DW'(flags[g*PINS +: PINS]);
    end
  end

  // reported source is latched and not masked
  p_enc_visible_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (status[irq_idx_o] && !mask[irq_idx_o]));

  // group line keeps its status bit set
  p_grp_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status & (DW'($past(grp)) << GBASE)) == (DW'($past(grp)) << GBASE)));

  p_irq_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == irq_valid_o);
endmodule

// File: tb/irq_ctrl_top_tb.sv
module irq_ctrl_top_tb_top;
  localparam int PERIOD = 10;
  localparam int GB = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  req = '0;
  logic [127:0] pins = '0;
  logic         we = 1'b0;
  logic [5:0]   addr = '0;
  logic [31:0]  wd = '0;
  logic [31:0]  rd;
  logic         irq, vld;
  logic [4:0]   idx;

  int checks = 0;
  int errors = 0;

  logic [31:0]  m_stat, m_mask;
  logic [127:0] m_flags;

  always #(PERIOD/2) clk = ~clk;

  irq_ctrl_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_req_i(req), .gpio_pin_i(pins),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wd), .reg_rdata_o(rd),
    .irq_o(irq), .irq_valid_o(vld), .irq_idx_o(idx)
  );

  function automatic int lowest(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic expect_eq(input string name, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", name, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [5:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rd;
  endtask

  task automatic check_all();
    logic [31:0] v, pe;
    pe = m_stat & ~m_mask;
    rd_reg(6'h00, v); expect_eq("R2 status", v, m_stat);
    rd_reg(6'h04, v); expect_eq("R4 mask", v, m_mask);
    rd_reg(6'h10, v); expect_eq("R3 pending", v, pe);
    for (int g = 0; g < 4; g++) begin
      rd_reg(6'(6'h20 + 4*g), v); expect_eq("R7 pin flags", v, m_flags[g*32 +: 32]);
    end
    expect_eq("R3 irq_o", 32'(irq), 32'(pe != 0));
    expect_eq("R6 valid", 32'(vld), 32'(pe != 0));
    if (pe != 0) expect_eq("R6 index", 32'(idx), 32'(lowest(pe)));
  endtask

  // one clock: drive at falling edge, model at rising edge, check after
  task automatic cyc(input logic [31:0] r, input logic [127:0] p,
                     input logic w, input logic [5:0] a, input logic [31:0] d);
    logic [31:0]  ns, nm;
    logic [127:0] nf;
    logic [3:0]   grp;
    @(negedge clk);
    req = r; pins = p; we = w; addr = a; wd = d;
    for (int g = 0; g < 4; g++) grp[g] = |m_flags[g*32 +: 32];
    ns = m_stat | r | (32'(grp) << GB);
    nm = m_mask;
    nf = m_flags | p;
    if (w) begin
      case (a[5:2])
        4'd1: nm = d;
        4'd2: nm = m_mask | d;
        4'd3: nm = m_mask & ~d;
        4'd5: ns = (m_stat & ~d) | r | (32'(grp) << GB);
        4'd8, 4'd9, 4'd10, 4'd11: begin
          for (int g = 0; g < 4; g++)
            if (a[5:2] == 4'(8 + g)) nf[g*32 +: 32] = (m_flags[g*32 +: 32] & ~d) | p[g*32 +: 32];
        end
        default: ;
      endcase
    end
    @(posedge clk);
    m_stat = ns; m_mask = nm; m_flags = nf;
    #1;
    req = '0; pins = '0; we = 1'b0;
    check_all();
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4711));
    m_stat = '0; m_mask = '1; m_flags = '0;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    // R1 reset state
    rd_reg(6'h04, v); expect_eq("R1 reset mask", v, 32'hFFFF_FFFF);
    rd_reg(6'h00, v); expect_eq("R1 reset status", v, 32'h0);
    expect_eq("R1 reset irq", 32'(irq), 0);
    check_all();

    // masked request latches but stays invisible
    cyc(32'h20, '0, 0, 0, 0);
    expect_eq("R3 masked source hidden", 32'(irq), 0);
    // R10 unmask latched source
    cyc('0, '0, 1, 6'h0C, 32'h20);
    expect_eq("R10 unmask shows irq", 32'(irq), 1);
    expect_eq("R10 unmask index", 32'(idx), 5);
    // R5 set wins over clear
    cyc(32'h20, '0, 1, 6'h14, 32'h20);
    rd_reg(6'h00, v); expect_eq("R5 set wins", v[5], 1);
    cyc('0, '0, 1, 6'h14, 32'h20);
    expect_eq("R5 clear drops irq", 32'(irq), 0);
    // R6 bits 23 and 27 (pin 96 -> group 3)
    cyc(32'h0080_0000, 128'(1) << 96, 0, 0, 0);
    cyc('0, '0, 1, 6'h08, 32'h0000_0000);
    cyc('0, '0, 1, 6'h04, 32'h0000_0000);
    expect_eq("R6 lowest of 23 and 27", 32'(idx), 23);
    // R8 group bit re-latches while flag set
    cyc('0, '0, 1, 6'h14, 32'h0880_0000);
    expect_eq("R8 group persists", 32'(idx), 27);
    cyc('0, '0, 1, 6'h2C, 32'h1);
    cyc('0, '0, 1, 6'h14, 32'h0800_0000);
    expect_eq("R8 group cleared", 32'(vld), 0);
    // R9 read-only writes ignored
    cyc(32'h3, '0, 0, 0, 0);
    cyc('0, '0, 1, 6'h00, 32'h0);
    cyc('0, '0, 1, 6'h10, 32'h0);
    rd_reg(6'h00, v); expect_eq("R9 status untouched", v, 32'h3);
    // mask set write restores masking
    cyc('0, '0, 1, 6'h08, 32'hFFFF_FFFF);
    expect_eq("R4 mask set hides all", 32'(irq), 0);

    for (int n = 0; n < 400; n++) begin
      logic [31:0]  r, d;
      logic [127:0] p;
      logic [5:0]   a;
      logic         w;
      int           sel;
      r = ($urandom % 4 == 0) ? (32'(1) << ($urandom % 32)) : '0;
      p = ($urandom % 5 == 0) ? (128'(1) << ($urandom % 128)) : '0;
      sel = $urandom % 8;
      w = sel < 6;
      d = $urandom & $urandom;
      case (sel)
        0: a = 6'h04;
        1: a = 6'h08;
        2: a = 6'h0C;
        3: a = 6'h14;
        4: a = 6'(6'h20 + 4 * ($urandom % 4));
        default: a = 6'h10;
      endcase
      if (sel == 4) d = $urandom;
      cyc(r, p, w, a, d);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule